// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps every in-flight instruction in a small circular queue, in the order the front end dispatches them. Dispatch writes an entry at the tail and returns its slot number as a tag. Execution units later report completions against that tag in any order. A result waits in its slot until retirement, and a source-operand lookup port can read a finished but unretired value by tag.

Retirement takes place only at the head and only in program order. A finished head entry with no fault drives a register-file write. A faulting entry does nothing until it reaches the head. At that point the block reports the fault and the faulting PC, and it empties the whole queue. A branch that completes with a misprediction discards every younger entry on the same clock edge, and the tail moves back to the slot after the branch.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `disp_ready_o` is 1, `commit_valid_o` and `exc_valid_o` are 0, and the first dispatch receives tag 0.
- R2: Each accepted dispatch (`disp_valid_i` and `disp_ready_o` both 1) receives tag `disp_tag_o`. Tags advance by one per dispatch and wrap from DEPTH-1 to 0.
- R3: With DEPTH entries occupied, `disp_ready_o` is 0. A dispatch and a retirement may occur in the same cycle, and the occupancy then stays unchanged.
- R4: A completion stores its result in the tagged entry. From the next cycle until retirement, a lookup of that tag returns `look_ready_o`=1 with the stored value.
- R5: `commit_valid_o` is 1 only while the head entry is finished and has no fault. It then shows that entry's destination and result. Retirements follow dispatch order even when completions arrive out of order.
- R6: A faulting entry at the head raises `exc_valid_o` for exactly one cycle with its PC on `exc_pc_o`, and it is never retired. On the next cycle the buffer is empty.
- R7: A fault on an entry behind the head has no effect until all older entries have retired. The next dispatch after the flush gets the faulting entry's tag.
- R8: A completion with `cmp_mispred_i`=1 and `cmp_exc_i`=0 discards all younger entries at that clock edge. The next dispatch gets tag (branch tag + 1) mod DEPTH. The branch itself and older entries still retire.
- R9: Discarded entries never retire. A completion or lookup that names a discarded or empty tag has no effect and reports `look_ready_o`=0.
- R10: `disp_ready_o` is 0 in any cycle where a mispredict flush or a fault flush takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_dest_i | input | AW | Destination register of the dispatched instruction |
| disp_pc_i | input | PCW | PC of the dispatched instruction |
| disp_ready_o | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag_o | output | TW | Tag given to the dispatched instruction |
| cmp_valid_i | input | 1 | Completion report |
| cmp_tag_i | input | TW | Tag of the completing instruction |
| cmp_value_i | input | DW | Result value |
| cmp_exc_i | input | 1 | Instruction faulted |
| cmp_mispred_i | input | 1 | Branch was mispredicted |
| commit_valid_o | output | 1 | Register-file write from the head this cycle |
| commit_dest_o | output | AW | Destination register of the retiring entry |
| commit_value_o | output | DW | Result of the retiring entry |
| exc_valid_o | output | 1 | Fault taken at the head this cycle |
| exc_pc_o | output | PCW | PC of the faulting instruction |
| look_tag_i | input | TW | Tag to read for an operand |
| look_ready_o | output | 1 | Tagged entry holds a finished result |
| look_value_o | output | DW | Result held by the tagged entry |

## Verification
The checker assumes that the units report completions only for tags that are live and not yet finished, and at most one completion per cycle. It also assumes that the consumer of `commit_valid_o` always accepts the write. The bench issues completions only for tags it received from dispatch. It sends a single completion per cycle and never completes a tag twice. The one exception is a deliberate stale completion to a discarded tag, which the block must ignore.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic done;
    logic exc;
    logic mispred;
  } rob_flags_t;

  // Distance of slot idx from the head in program order.
  function automatic int unsigned rob_age(int unsigned idx, int unsigned head,
                                          int unsigned depth);
    return (idx >= head) ? idx - head : idx + depth - head;
  endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 6,
  parameter int TW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          retire_i,
  input  logic          flush_all_i,
  input  logic          flush_br_i,
  input  logic [TW-1:0] br_tag_i,
  output logic [TW-1:0] head_o,
  output logic [TW-1:0] tail_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [TW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic [CW-1:0] br_keep;

  function automatic logic [TW-1:0] nxt(logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Entries kept on a mispredict: head through branch inclusive.
  assign br_keep = CW'(rob_pkg::rob_age(int'(br_tag_i), int'(head_q), DEPTH) + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_all_i) begin
      tail_q  <= head_q;
      count_q <= '0;
    end else if (flush_br_i) begin
      tail_q  <= nxt(br_tag_i);
      count_q <= br_keep - CW'(retire_i);
      if (retire_i) head_q <= nxt(head_q);
    end else begin
      if (retire_i) head_q <= nxt(head_q);
      if (alloc_i)  tail_q <= nxt(tail_q);
      count_q <= count_q + CW'(alloc_i) - CW'(retire_i);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
endmodule

// File: rtl/rob_slot.sv
module rob_slot import rob_pkg::*; #(
  parameter int AW  = 5,
  parameter int PCW = 32,
  parameter int DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           alloc_i,
  input  logic [AW-1:0]  dest_i,
  input  logic [PCW-1:0] pc_i,
  input  logic           cmp_i,
  input  logic [DW-1:0]  value_i,
  input  logic           exc_i,
  input  logic           mispred_i,
  input  logic           retire_i,
  input  logic           kill_i,
  output logic           valid_o,
  output rob_flags_t     flags_o,
  output logic [AW-1:0]  dest_o,
  output logic [PCW-1:0] pc_o,
  output logic [DW-1:0]  value_o
);
  logic       valid_q;
  rob_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end else if (kill_i) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      flags_q <= '0;
    end else if (retire_i) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end else if (cmp_i && valid_q) begin
      flags_q <= '{done: 1'b1, exc: exc_i, mispred: mispred_i};
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      dest_o <= dest_i;
      pc_o   <= pc_i;
    end
    if (cmp_i && valid_q) value_o <= value_i;
  end

  assign valid_o = valid_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf import rob_pkg::*; #(
  parameter int DEPTH = 6,
  parameter int AW    = 5,
  parameter int PCW   = 32,
  parameter int DW    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       disp_valid_i,
  input  logic [AW-1:0]              disp_dest_i,
  input  logic [PCW-1:0]             disp_pc_i,
  output logic                       disp_ready_o,
  output logic [$clog2(DEPTH)-1:0]   disp_tag_o,
  input  logic                       cmp_valid_i,
  input  logic [$clog2(DEPTH)-1:0]   cmp_tag_i,
  input  logic [DW-1:0]              cmp_value_i,
  input  logic                       cmp_exc_i,
  input  logic                       cmp_mispred_i,
  output logic                       commit_valid_o,
  output logic [AW-1:0]              commit_dest_o,
  output logic [DW-1:0]              commit_value_o,
  output logic                       exc_valid_o,
  output logic [PCW-1:0]             exc_pc_o,
  input  logic [$clog2(DEPTH)-1:0]   look_tag_i,
  output logic                       look_ready_o,
  output logic [DW-1:0]              look_value_o
);
  localparam int TW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic             full;
  logic [DEPTH-1:0] s_valid, kill;
  rob_flags_t       s_flags [DEPTH];
  logic [AW-1:0]    s_dest  [DEPTH];
  logic [PCW-1:0]   s_pc    [DEPTH];
  logic [DW-1:0]    s_value [DEPTH];

  logic head_done, head_exc, cmp_hit, br_flush, alloc, retire;

  assign head_done = s_valid[head] && s_flags[head].done;
  assign head_exc  = head_done && s_flags[head].exc;
  assign retire    = head_done && !s_flags[head].exc;
  assign cmp_hit   = cmp_valid_i && (cmp_tag_i < TW'(DEPTH)) && s_valid[cmp_tag_i];
  assign br_flush  = cmp_hit && cmp_mispred_i && !cmp_exc_i && !head_exc;

  assign disp_ready_o = !full && !br_flush && !head_exc;
  assign disp_tag_o   = tail;
  assign alloc        = disp_valid_i && disp_ready_o;

  assign commit_valid_o = retire;
  assign commit_dest_o  = s_dest[head];
  assign commit_value_o = s_value[head];
  assign exc_valid_o    = head_exc;
  assign exc_pc_o       = s_pc[head];

  assign look_ready_o = (look_tag_i < TW'(DEPTH)) && s_valid[look_tag_i] &&
                        s_flags[look_tag_i].done;
  assign look_value_o = s_value[look_tag_i];

  rob_ptrs #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .retire_i    (retire),
    .flush_all_i (head_exc),
    .flush_br_i  (br_flush),
    .br_tag_i    (cmp_tag_i),
    .head_o      (head),
    .tail_o      (tail),
    .count_o     (count),
    .full_o      (full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign kill[g] = head_exc ||
      (br_flush && (rob_age(g, int'(head), DEPTH) > rob_age(int'(cmp_tag_i), int'(head), DEPTH)));

    rob_slot #(.AW(AW), .PCW(PCW), .DW(DW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (alloc && (tail == TW'(g))),
      .dest_i    (disp_dest_i),
      .pc_i      (disp_pc_i),
      .cmp_i     (cmp_valid_i && (cmp_tag_i == TW'(g))),
      .value_i   (cmp_value_i),
      .exc_i     (cmp_exc_i),
      .mispred_i (cmp_mispred_i),
      .retire_i  (retire && (head == TW'(g))),
      .kill_i    (kill[g]),
      .valid_o   (s_valid[g]),
      .flags_o   (s_flags[g]),
      .dest_o    (s_dest[g]),
      .pc_o      (s_pc[g]),
      .value_o   (s_value[g])
    );
  end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 6,
  parameter int TW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] count_i,
  input logic [TW-1:0] tail_i,
  input logic          disp_ready_i,
  input logic          alloc_i,
  input logic          br_flush_i,
  input logic [TW-1:0] cmp_tag_i,
  input logic          commit_valid_i,
  input logic          exc_valid_i
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  assert_full_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CW'(DEPTH)) |-> !disp_ready_i);

  assert_commit_or_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_valid_i && exc_valid_i));

  assert_fault_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> (count_i == '0));

  assert_mispredict_tail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_flush_i |=> (tail_i == (($past(cmp_tag_i) == TW'(DEPTH - 1)) ? '0 : $past(cmp_tag_i) + 1'b1)));

  assert_flush_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_flush_i || exc_valid_i) |-> !disp_ready_i);

  assert_retire_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && !alloc_i && !br_flush_i) |=> (count_i == $past(count_i) - 1'b1));
endmodule

bind reorder_buf rob_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .count_i        (count),
  .tail_i         (tail),
  .disp_ready_i   (disp_ready_o),
  .alloc_i        (alloc),
  .br_flush_i     (br_flush),
  .cmp_tag_i      (cmp_tag_i),
  .commit_valid_i (commit_valid_o),
  .exc_valid_i    (exc_valid_o)
);

// File: tb/reorder_buf_test.sv
module reorder_buf_test;
  localparam int DEPTH = 6;
  localparam int AW = 5, PCW = 32, DW = 32;
  localparam int TW = $clog2(DEPTH);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic disp_valid_i = 0;
  logic [AW-1:0] disp_dest_i = '0;
  logic [PCW-1:0] disp_pc_i = '0;
  logic disp_ready_o;
  logic [TW-1:0] disp_tag_o;
  logic cmp_valid_i = 0, cmp_exc_i = 0, cmp_mispred_i = 0;
  logic [TW-1:0] cmp_tag_i = '0, look_tag_i = '0;
  logic [DW-1:0] cmp_value_i = '0;
  logic commit_valid_o, exc_valid_o, look_ready_o;
  logic [AW-1:0] commit_dest_o;
  logic [DW-1:0] commit_value_o, look_value_o;
  logic [PCW-1:0] exc_pc_o;

  always #10 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .AW(AW), .PCW(PCW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid_i), .disp_dest_i(disp_dest_i), .disp_pc_i(disp_pc_i),
    .disp_ready_o(disp_ready_o), .disp_tag_o(disp_tag_o),
    .cmp_valid_i(cmp_valid_i), .cmp_tag_i(cmp_tag_i), .cmp_value_i(cmp_value_i),
    .cmp_exc_i(cmp_exc_i), .cmp_mispred_i(cmp_mispred_i),
    .commit_valid_o(commit_valid_o), .commit_dest_o(commit_dest_o),
    .commit_value_o(commit_value_o), .exc_valid_o(exc_valid_o), .exc_pc_o(exc_pc_o),
    .look_tag_i(look_tag_i), .look_ready_o(look_ready_o), .look_value_o(look_value_o)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int log_dest [64];
  int log_val  [64];
  int log_n = 0, exc_n = 0, exc_pc_seen = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Retirement monitor, samples mid-phase away from edges.
  always begin
    @(negedge clk);
    #5;
    if (rst_ni && commit_valid_o && log_n < 64) begin
      log_dest[log_n] = int'(commit_dest_o);
      log_val[log_n]  = int'(commit_value_o);
      log_n++;
    end
    if (rst_ni && exc_valid_o) begin
      exc_n++;
      exc_pc_seen = int'(exc_pc_o);
    end
  end

  task automatic clear_log();
    log_n = 0;
    exc_n = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic disp(int dest, int pc, output int tag, output bit ok);
    disp_valid_i = 1;
    disp_dest_i  = AW'(dest);
    disp_pc_i    = PCW'(pc);
    #1;
    ok  = disp_ready_o;
    tag = int'(disp_tag_o);
    @(negedge clk);
    disp_valid_i = 0;
  endtask

  task automatic cmp(int tag, int val, bit exc, bit mis, output bit rdy);
    cmp_valid_i   = 1;
    cmp_tag_i     = TW'(tag);
    cmp_value_i   = DW'(val);
    cmp_exc_i     = exc;
    cmp_mispred_i = mis;
    #1;
    rdy = disp_ready_o;
    @(negedge clk);
    cmp_valid_i = 0;
    cmp_exc_i = 0;
    cmp_mispred_i = 0;
  endtask

  task automatic test_reset();
    #1;
    chk(disp_ready_o == 1, "R1 ready", disp_ready_o, 1);
    chk(commit_valid_o == 0, "R1 commit", commit_valid_o, 0);
    chk(exc_valid_o == 0, "R1 exc", exc_valid_o, 0);
    chk(disp_tag_o == 0, "R1 tag", disp_tag_o, 0);
  endtask

  task automatic test_fill_ooo();
    int tag; bit ok, r;
    int order [6] = '{3, 1, 0, 2, 5, 4};
    clear_log();
    for (int k = 0; k < 6; k++) begin
      disp(k + 1, 'h100 + 4 * k, tag, ok);
      chk(ok && tag == k, "R2 tag order", tag, k);
    end
    #1;
    chk(disp_ready_o == 0, "R3 full stall", disp_ready_o, 0);
    cmp(3, 203, 0, 0, r);
    look_tag_i = 3;
    #1;
    chk(look_ready_o == 1 && look_value_o == 203, "R4 lookup", int'(look_value_o), 203);
    chk(commit_valid_o == 0, "R5 head not done", commit_valid_o, 0);
    for (int k = 1; k < 6; k++) cmp(order[k], 200 + order[k], 0, 0, r);
    idle(8);
    chk(log_n == 6, "R5 retire count", log_n, 6);
    for (int k = 0; k < 6; k++)
      chk(log_dest[k] == k + 1 && log_val[k] == 200 + k, "R5 retire order", log_dest[k], k + 1);
  endtask

  task automatic test_alloc_retire();
    int tag; bit ok, r;
    clear_log();
    disp(20, 'h200, tag, ok);
    cmp(tag, 500, 0, 0, r);
    disp_valid_i = 1;
    disp_dest_i  = 21;
    #1;
    chk(commit_valid_o == 1 && disp_ready_o == 1, "R3 alloc with retire",
        {commit_valid_o, disp_ready_o}, 3);
    @(negedge clk);
    disp_valid_i = 0;
    for (int k = 0; k < 5; k++) begin
      disp(22 + k, 'h210 + 4 * k, tag, ok);
      chk(ok == 1, "R3 room after retire", ok, 1);
      chk(tag == (2 + k) % DEPTH, "R2 wrap", tag, (2 + k) % DEPTH);
    end
    #1;
    chk(disp_ready_o == 0, "R3 full again", disp_ready_o, 0);
    for (int k = 1; k <= 6; k++) cmp(k % DEPTH, 600 + k, 0, 0, r);
    idle(9);
    chk(log_n == 7, "R3 retire count", log_n, 7);
    chk(log_dest[6] == 26 && log_val[6] == 606, "R5 last retire", log_dest[6], 26);
  endtask

  task automatic test_fault();
    int ta, tb, tc, td; bit ok, r;
    clear_log();
    disp(7, 'h300, ta, ok);
    disp(8, 'h304, tb, ok);
    disp(9, 'h308, tc, ok);
    cmp(tc, 77, 1, 0, r);
    idle(2);
    chk(exc_n == 0, "R7 fault waits", exc_n, 0);
    cmp(tb, 71, 0, 0, r);
    cmp(ta, 70, 0, 0, r);
    idle(5);
    chk(log_n == 2 && log_dest[0] == 7 && log_dest[1] == 8, "R7 older retire", log_n, 2);
    chk(exc_n == 1, "R6 single pulse", exc_n, 1);
    chk(exc_pc_seen == 'h308, "R6 fault pc", exc_pc_seen, 'h308);
    #1;
    chk(disp_ready_o == 1, "R6 empty after", disp_ready_o, 1);
    disp(10, 'h30c, td, ok);
    chk(td == tc, "R7 tag reuse", td, tc);
    cmp(td, 80, 0, 0, r);
    idle(3);
    chk(log_n == 3 && log_dest[2] == 10, "R6 resume", log_dest[2], 10);
  endtask

  task automatic test_mispredict();
    int to, tbr, ty1, ty2, tn; bit ok, r;
    clear_log();
    disp(11, 'h400, to, ok);
    disp(12, 'h404, tbr, ok);
    disp(13, 'h408, ty1, ok);
    disp(14, 'h40c, ty2, ok);
    cmp(ty1, 90, 0, 0, r);
    cmp(tbr, 91, 0, 1, r);
    chk(r == 0, "R10 stall on flush", r, 0);
    look_tag_i = TW'(ty1);
    #1;
    chk(look_ready_o == 0, "R9 flushed lookup", look_ready_o, 0);
    cmp(ty2, 95, 0, 0, r);
    look_tag_i = TW'(ty2);
    #1;
    chk(look_ready_o == 0, "R9 stale completion", look_ready_o, 0);
    disp(15, 'h500, tn, ok);
    chk(tn == (tbr + 1) % DEPTH, "R8 tail after branch", tn, (tbr + 1) % DEPTH);
    cmp(to, 92, 0, 0, r);
    cmp(tn, 93, 0, 0, r);
    idle(5);
    chk(log_n == 3, "R9 no flushed retire", log_n, 3);
    chk(log_dest[0] == 11 && log_dest[1] == 12 && log_dest[2] == 15,
        "R8 branch retires", log_dest[1], 12);
  endtask

  initial begin
    idle(3);
    rst_ni = 1;
    @(negedge clk);
    test_reset();
    test_fill_ooo();
    test_alloc_retire();
    test_fault();
    test_mispredict();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule